// File: doc/BRIEF.md
# Sixteen-Operation Field ALU

A purely combinational datapath unit that turns two source words and a 4-bit operation code into one result word. Besides the usual move, add, two subtraction orders and bitwise logic, it covers the operations used for bit-field and byte handling. A combined (funnel) left shift joins two words under a count held in an auxiliary Lo register. Byte extract and byte insert move one byte between words. Logical and arithmetic shifts and a rotate take their count from the instruction's immediate field.

An execution stage places one instance after its operand multiplexers. Source 1 is the first source operand, or the raw 4-bit immediate field in its low nibble. Source 2 is the second operand, which is also the current value of the destination. Two operation codes are escapes to extended operations. Here they return zero and raise a flag so that a neighbouring decoder can take over. A parameter chooses between one shared funnel shifter and separate shift operators. Both give identical results.

Top module: `fieldops_alu`

## Requirements
- R1: Code 0000 with imm_bit low returns src_a unchanged. src_b has no effect.
- R2: Code 0000 with imm_bit high returns the sign extension of the byte {mov_hi_nib, src_a[3:0]}. mov_hi_nib supplies bits 7:4.
- R3: Code 0001 returns src_a + src_b modulo 2^32.
- R4: Code 0010 returns src_b - src_a modulo 2^32.
- R5: Code 0011 returns src_a - src_b modulo 2^32.
- R6: Codes 0100, 0101 and 0110 return the bitwise AND, OR and XOR of the two sources.
- R7: Code 0111 with count sc = lo_bits (1 to 31) returns src_b[31-sc:0] in the upper bits, followed by src_a[31:32-sc] in the low sc bits.
- R8: Code 0111 with lo_bits = 0 returns src_b unchanged.
- R9: Codes 1000, 1001 and 1010 shift src_b left logically, right logically and right arithmetically by the count {imm_bit, src_a[3:0]}. imm_bit is bit 4 of the count, and lo_bits has no effect.
- R10: Code 1011 rotates src_b left by {imm_bit, src_a[3:0]}. A count of 0 returns src_b.
- R11: Code 1100 returns byte number src_a[1:0] of src_b in bits 7:0, with bits 31:8 cleared. Byte n is bits 8n+7:8n.
- R12: Code 1101 returns src_b with byte number lo_bits[1:0] replaced by src_a[7:0]. All other bytes are unchanged.
- R13: Codes 1110 and 1111 return zero with ext_op high. For every other code, ext_op is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| src_a | input | 32 | Source 1 (register value or immediate field in the low nibble) |
| src_b | input | 32 | Source 2, also the current destination value |
| lo_bits | input | 5 | Low bits of the Lo register: funnel count, insert byte position |
| imm_bit | input | 1 | Immediate flag: selects immediate move, forms bit 4 of shift counts |
| mov_hi_nib | input | 4 | Upper nibble of the immediate move byte |
| result | output | 32 | Operation result |
| ext_op | output | 1 | High for the two escape codes |

## Verification
Within one cycle, lo_bits can carry a count that one function must use while another function must ignore it. The funnel shift and byte insert read it, while the immediate shifts and rotate must not. imm_bit is likewise read as a move selector by code 0000 and as a count bit by the shifts. The bench keeps lo_bits and imm_bit non-zero and changing while it issues immediate shifts, moves and escapes back to back with funnel and insert operations. Every cycle's result and flag are compared with a behavioural model that computes each count only from the fields its requirement names.

// File: rtl/fieldalu_pkg.sv
package fieldalu_pkg;

   typedef enum logic [3:0] {
      OP_MOVE    = 4'd0,
      OP_ADD     = 4'd1,
      OP_SUB     = 4'd2,
      OP_RSUB    = 4'd3,
      OP_AND     = 4'd4,
      OP_OR      = 4'd5,
      OP_XOR     = 4'd6,
      OP_FUNNEL  = 4'd7,
      OP_SLL     = 4'd8,
      OP_SRL     = 4'd9,
      OP_SRA     = 4'd10,
      OP_ROL     = 4'd11,
      OP_XBYTE   = 4'd12,
      OP_IBYTE   = 4'd13,
      OP_ESC_SRC = 4'd14,
      OP_ESC_DST = 4'd15
   } alu_op_e;

   typedef enum logic [2:0] {
      SK_NONE   = 3'd0,
      SK_SLL    = 3'd1,
      SK_SRL    = 3'd2,
      SK_SRA    = 3'd3,
      SK_ROL    = 3'd4,
      SK_FUNNEL = 3'd5
   } shift_kind_e;

endpackage

// File: rtl/fieldalu_arith.sv
module fieldalu_arith
   import fieldalu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              imm_sel,
   input  logic [3:0]        hi_nib,
   output logic [DATA_W-1:0] res
);
   localparam int EXT_W = DATA_W - 8;

   logic [7:0]        imm_byte;
   logic [DATA_W-1:0] imm_word;

   assign imm_byte = {hi_nib, opnd_a[3:0]};
   assign imm_word = {{EXT_W{imm_byte[7]}}, imm_byte};

   always_comb begin
      case (op)
         OP_MOVE: res = imm_sel ? imm_word : opnd_a;
         OP_ADD:  res = opnd_a + opnd_b;
         OP_SUB:  res = opnd_b - opnd_a;
         OP_RSUB: res = opnd_a - opnd_b;
         OP_AND:  res = opnd_a & opnd_b;
         OP_OR:   res = opnd_a | opnd_b;
         OP_XOR:  res = opnd_a ^ opnd_b;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/fieldalu_shift.sv
module fieldalu_shift
   import fieldalu_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter bit SHARED_FUNNEL = 1'b1,
   localparam int SHAMT_W      = $clog2(DATA_W)
) (
   input  shift_kind_e        kind,
   input  logic [DATA_W-1:0]  opnd_a,
   input  logic [DATA_W-1:0]  opnd_b,
   input  logic [SHAMT_W-1:0] amt,
   output logic [DATA_W-1:0]  shifted
);
   generate
      if (SHARED_FUNNEL) begin : g_funnel
         localparam logic [SHAMT_W:0] SH_FULL = (SHAMT_W+1)'(DATA_W);
         logic [DATA_W-1:0]   upper;
         logic [DATA_W-1:0]   lower;
         logic [SHAMT_W:0]    famt;
         logic [2*DATA_W-1:0] wide;

         always_comb begin
            upper = '0;
            lower = '0;
            famt  = '0;
            case (kind)
               SK_SLL: begin
                  upper = opnd_b;
                  famt  = {1'b0, amt};
               end
               SK_ROL: begin
                  upper = opnd_b;
                  lower = opnd_b;
                  famt  = {1'b0, amt};
               end
               SK_FUNNEL: begin
                  upper = opnd_b;
                  lower = opnd_a;
                  famt  = {1'b0, amt};
               end
               SK_SRL: begin
                  lower = opnd_b;
                  famt  = SH_FULL - {1'b0, amt};
               end
               SK_SRA: begin
                  upper = {DATA_W{opnd_b[DATA_W-1]}};
                  lower = opnd_b;
                  famt  = SH_FULL - {1'b0, amt};
               end
               default: ;
            endcase
            wide    = {upper, lower} << famt;
            shifted = (kind == SK_NONE) ? '0 : wide[2*DATA_W-1:DATA_W];
         end
      end else begin : g_direct
         always_comb begin
            case (kind)
               SK_SLL:    shifted = opnd_b << amt;
               SK_SRL:    shifted = opnd_b >> amt;
               SK_SRA:    shifted = DATA_W'($signed(opnd_b) >>> amt);
               SK_ROL:    shifted = (amt == '0) ? opnd_b
                                  : (opnd_b << amt) | (opnd_b >> (DATA_W - int'(amt)));
               SK_FUNNEL: shifted = (amt == '0) ? opnd_b
                                  : (opnd_b << amt) | (opnd_a >> (DATA_W - int'(amt)));
               default:   shifted = '0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/fieldalu_bytes.sv
module fieldalu_bytes #(
   parameter int DATA_W  = 32,
   localparam int NBYTES = DATA_W / 8,
   localparam int BSEL_W = $clog2(NBYTES)
) (
   input  logic [DATA_W-1:0] word_b,
   input  logic [7:0]        new_byte,
   input  logic [BSEL_W-1:0] xsel,
   input  logic [BSEL_W-1:0] isel,
   output logic [DATA_W-1:0] extracted,
   output logic [DATA_W-1:0] inserted
);
   logic [7:0] picked;

   always_comb begin
      picked = '0;
      for (int k = 0; k < NBYTES; k++) begin
         if (xsel == BSEL_W'(k)) picked = word_b[k*8 +: 8];
      end
      extracted = {{(DATA_W-8){1'b0}}, picked};
   end

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         assign inserted[g*8 +: 8] = (isel == BSEL_W'(g)) ? new_byte : word_b[g*8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/fieldops_alu.sv
module fieldops_alu
   import fieldalu_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter bit SHARED_FUNNEL = 1'b1
) (
   input  logic [3:0]                 op_code,
   input  logic [DATA_W-1:0]          src_a,
   input  logic [DATA_W-1:0]          src_b,
   input  logic [$clog2(DATA_W)-1:0]  lo_bits,
   input  logic                       imm_bit,
   input  logic [3:0]                 mov_hi_nib,
   output logic [DATA_W-1:0]          result,
   output logic                       ext_op
);
   localparam int SHAMT_W = $clog2(DATA_W);
   localparam int NBYTES  = DATA_W / 8;
   localparam int BSEL_W  = $clog2(NBYTES);

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0 || (1 << SHAMT_W) != DATA_W) begin : g_bad_width
         $error("fieldops_alu: DATA_W must be a power of two of at least 16");
      end
   endgenerate

   alu_op_e            op;
   shift_kind_e        kind;
   logic [SHAMT_W-1:0] imm_cnt;
   logic [SHAMT_W-1:0] sh_amt;
   logic [DATA_W-1:0]  arith_res;
   logic [DATA_W-1:0]  shift_res;
   logic [DATA_W-1:0]  xbyte_res;
   logic [DATA_W-1:0]  ibyte_res;

   assign op      = alu_op_e'(op_code);
   assign imm_cnt = {imm_bit, src_a[SHAMT_W-2:0]};

   always_comb begin
      case (op)
         OP_SLL:    kind = SK_SLL;
         OP_SRL:    kind = SK_SRL;
         OP_SRA:    kind = SK_SRA;
         OP_ROL:    kind = SK_ROL;
         OP_FUNNEL: kind = SK_FUNNEL;
         default:   kind = SK_NONE;
      endcase
      sh_amt = (op == OP_FUNNEL) ? lo_bits : imm_cnt;
   end

   fieldalu_arith #(.DATA_W(DATA_W)) u_arith (
      .op      (op),
      .opnd_a  (src_a),
      .opnd_b  (src_b),
      .imm_sel (imm_bit),
      .hi_nib  (mov_hi_nib),
      .res     (arith_res)
   );

   fieldalu_shift #(.DATA_W(DATA_W), .SHARED_FUNNEL(SHARED_FUNNEL)) u_shift (
      .kind    (kind),
      .opnd_a  (src_a),
      .opnd_b  (src_b),
      .amt     (sh_amt),
      .shifted (shift_res)
   );

   fieldalu_bytes #(.DATA_W(DATA_W)) u_bytes (
      .word_b    (src_b),
      .new_byte  (src_a[7:0]),
      .xsel      (src_a[BSEL_W-1:0]),
      .isel      (lo_bits[BSEL_W-1:0]),
      .extracted (xbyte_res),
      .inserted  (ibyte_res)
   );

   always_comb begin
      ext_op = 1'b0;
      case (op)
         OP_FUNNEL, OP_SLL, OP_SRL, OP_SRA, OP_ROL: result = shift_res;
         OP_XBYTE:               result = xbyte_res;
         OP_IBYTE:               result = ibyte_res;
         OP_ESC_SRC, OP_ESC_DST: begin
            result = '0;
            ext_op = 1'b1;
         end
         default:                result = arith_res;
      endcase
   end

   always_comb begin
      automatic int lanes_changed = 0;
      for (int k = 0; k < NBYTES; k++) begin
         if (result[k*8 +: 8] != src_b[k*8 +: 8]) lanes_changed++;
      end
      if (ext_op) begin
         AST_ESCAPE_ZERO: assert (result == '0); // R13
      end
      if (op == OP_XBYTE) begin
         AST_XBYTE_UPPER_CLEAR: assert (result[DATA_W-1:8] == '0); // R11
      end
      if (op == OP_IBYTE) begin
         AST_IBYTE_ONE_LANE: assert (lanes_changed <= 1); // R12
      end
      if (op == OP_FUNNEL && lo_bits == '0) begin
         AST_FUNNEL_ZERO_PASS: assert (result == src_b); // R8
      end
      if (op == OP_SUB) begin
         AST_SUB_INVERSE: assert (result + src_a == src_b); // R4
      end
      if (op == OP_RSUB) begin
         AST_RSUB_INVERSE: assert (result + src_b == src_a); // R5
      end
   end
endmodule

// File: tb/sim_fieldops_alu.sv
`timescale 1ns/1ps
module sim_fieldops_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_code = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [4:0]  lo_bits = '0;
   logic        imm_bit = 1'b0;
   logic [3:0]  mov_hi_nib = '0;
   logic [31:0] result;
   logic        ext_op;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fieldops_alu u0 (
      .op_code    (op_code),
      .src_a      (src_a),
      .src_b      (src_b),
      .lo_bits    (lo_bits),
      .imm_bit    (imm_bit),
      .mov_hi_nib (mov_hi_nib),
      .result     (result),
      .ext_op     (ext_op)
   );

   function automatic string tag_of(input logic [3:0] op, input logic imm);
      case (op)
         4'd0:        return imm ? "R2 imm move" : "R1 move";
         4'd1:        return "R3 add";
         4'd2:        return "R4 sub";
         4'd3:        return "R5 rsub";
         4'd4, 4'd5, 4'd6: return "R6 logic";
         4'd7:        return "R7/R8 funnel";
         4'd8, 4'd9, 4'd10: return "R9 imm shift";
         4'd11:       return "R10 rotate";
         4'd12:       return "R11 extract";
         4'd13:       return "R12 insert";
         default:     return "R13 escape";
      endcase
   endfunction

   function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] lo,
                                         input logic imm, input logic [3:0] nib);
      int cnt;
      int sel;
      logic [31:0] r;
      cnt = {27'd0, imm, a[3:0]};
      r = '0;
      case (op)
         4'd0:  r = imm ? {{24{nib[3]}}, nib, a[3:0]} : a;
         4'd1:  r = a + b;
         4'd2:  r = b - a;
         4'd3:  r = a - b;
         4'd4:  r = a & b;
         4'd5:  r = a | b;
         4'd6:  r = a ^ b;
         4'd7:  begin
            for (int i = 0; i < 32; i++) begin
               if (i < int'(lo)) r[i] = a[32 - int'(lo) + i];
               else              r[i] = b[i - int'(lo)];
            end
         end
         4'd8:  r = b << cnt;
         4'd9:  r = b >> cnt;
         4'd10: begin
            for (int i = 0; i < 32; i++) r[i] = (i + cnt > 31) ? b[31] : b[i + cnt];
         end
         4'd11: begin
            for (int i = 0; i < 32; i++) r[i] = b[(i - cnt + 32) % 32];
         end
         4'd12: begin
            sel = int'(a[1:0]);
            r = (b >> (8 * sel)) & 32'h0000_00FF;
         end
         4'd13: begin
            sel = int'(lo[1:0]);
            r = b;
            r[8*sel +: 8] = a[7:0];
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check_now(input string tag);
      logic [31:0] exp_r;
      logic        exp_x;
      exp_r = model(op_code, src_a, src_b, lo_bits, imm_bit, mov_hi_nib);
      exp_x = (op_code == 4'd14) || (op_code == 4'd15);
      checks++;
      if (result !== exp_r || ext_op !== exp_x) begin
         errors++;
         $display("FAIL %s op=%0d actual=%h/%b expected=%h/%b",
                  tag, op_code, result, ext_op, exp_r, exp_x);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] lo, input logic imm, input logic [3:0] nib,
                        input string tag);
      @(posedge clk);
      op_code = op; src_a = a; src_b = b; lo_bits = lo; imm_bit = imm; mov_hi_nib = nib;
      @(negedge clk);
      check_now(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_now("R1 reset state");
      rst_n = 1'b1;
      // R1 / R2
      apply(4'd0, 32'hDEADBEEF, 32'h1234_5678, 5'd9, 1'b0, 4'h3, "R1 move ignores src_b");
      apply(4'd0, 32'h0000_0005, 32'hFFFF_0000, 5'd0, 1'b1, 4'hA, "R2 negative byte");
      apply(4'd0, 32'hFFFF_FFFF, 32'h0, 5'd3, 1'b1, 4'h7, "R2 positive byte");
      // R3..R6
      apply(4'd1, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b0, 4'h0, "R3 add wrap");
      apply(4'd2, 32'd7, 32'd5, 5'd0, 1'b0, 4'h0, "R4 sub b-a");
      apply(4'd3, 32'd7, 32'd5, 5'd0, 1'b0, 4'h0, "R5 rsub a-b");
      apply(4'd4, 32'hF0F0_1234, 32'hFF00_FF00, 5'd0, 1'b0, 4'h0, "R6 and");
      apply(4'd5, 32'hF0F0_1234, 32'hFF00_FF00, 5'd0, 1'b0, 4'h0, "R6 or");
      apply(4'd6, 32'hF0F0_1234, 32'hFF00_FF00, 5'd0, 1'b0, 4'h0, "R6 xor");
      // R7 / R8, interleaved with Lo-ignoring immediate shifts (R9)
      apply(4'd7, 32'hABCD_EF01, 32'h1234_5678, 5'd0, 1'b1, 4'h0, "R8 funnel count zero");
      apply(4'd7, 32'hABCD_EF01, 32'h1234_5678, 5'd4, 1'b0, 4'h0, "R7 funnel by 4");
      apply(4'd8, 32'h0000_0000, 32'h0000_ABCD, 5'd4, 1'b1, 4'h0, "R9 sll by 16, lo ignored");
      apply(4'd7, 32'h8000_0001, 32'h0000_0003, 5'd31, 1'b0, 4'h0, "R7 funnel by 31");
      apply(4'd9, 32'h0000_0004, 32'h8000_0000, 5'd31, 1'b0, 4'h0, "R9 srl by 4");
      apply(4'd10, 32'h0000_000F, 32'h8000_0000, 5'd17, 1'b1, 4'h0, "R9 sra by 31");
      apply(4'd10, 32'h0000_0001, 32'h4000_0000, 5'd2, 1'b0, 4'h0, "R9 sra positive");
      apply(4'd11, 32'h0000_0000, 32'h8000_0001, 5'd5, 1'b0, 4'h0, "R10 rotate by 0");
      apply(4'd11, 32'h0000_000F, 32'h8000_0001, 5'd5, 1'b1, 4'h0, "R10 rotate by 31");
      // R11 / R12
      for (int s = 0; s < 4; s++) begin
         apply(4'd12, 32'hFFFF_FFF0 | s, 32'h4433_2211, 5'd0, 1'b0, 4'h0, "R11 extract lane");
         apply(4'd13, 32'h1234_56A5, 32'h4433_2211, 5'(28 + s), 1'b1, 4'h0, "R12 insert lane");
      end
      // R13
      apply(4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 1'b1, 4'hF, "R13 escape src");
      apply(4'd15, 32'h1357_9BDF, 32'h2468_ACE0, 5'd7, 1'b0, 4'h5, "R13 escape dst");
      // mixed sweep
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] op;
         op = 4'($urandom_range(0, 15));
         apply(op, $urandom, $urandom, 5'($urandom), 1'($urandom), 4'($urandom), tag_of(op, imm_bit));
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R1-all actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule